// File: doc/BRIEF.md
# Interrupt Source P/Q State Controller

This block keeps the delivery state of a small bank of interrupt sources and decides when an event must be forwarded for routing. Each source holds a two-bit P/Q state, with P (pending) as the upper bit and Q (queued) as the lower bit. It also holds a type bit, which selects level or message behaviour, and an asserted flag that follows the input line of a level source. The P/Q state of four sources shares one byte of state storage.

Sources change state from three places: their input lines, a load/store management port, and reset. The management port carries a page select bit. A store to the even (trigger) page acts as a software trigger. Loads and stores to the odd (management) page carry an end-of-interrupt, a state query or a state overwrite. Whenever a source needs routing, the block emits a one-cycle notify pulse carrying the source number. Requests that arrive together are served lowest number first, one per cycle.

Message sources use the full P/Q scheme and can queue a second event. Level sources use only P together with the asserted flag. They never queue an event. Instead they fire again after an end-of-interrupt for as long as their line stays high.

Top module: `pqsrc_ctrl`

## Requirements
- R1: A management load returns, on `mg_rdata` in the cycle after the load with `mg_rvalid` high for that one cycle, the addressed source's P/Q value as it was before the load's own operation (P is bit 1, Q is bit 0; 00 idle, 10 pending, 11 queued, 01 off). A store never raises `mg_rvalid`.
- R2: Reset puts every source in state 01 (off), clears every asserted flag and every waiting notify, and holds `ntf_valid` and `mg_rvalid` low.
- R3: The type bit of a source (1 = level, 0 = message) is written only through the configuration port and keeps its value across reset.
- R4: A message source triggers on a rising input line or on a management store with `mg_odd_page` = 0. A trigger takes 00 to 10 with a notify, takes 10 or 11 to 11 with no notify, and leaves 01 unchanged. A line that is held high or falls has no effect.
- R5: A level source fires when its line is high and its state is 00. Firing sets the state to 10 and raises a notify. A falling line never notifies, and a store with `mg_odd_page` = 0 has no effect on a level source.
- R6: End-of-interrupt (`mg_odd_page` = 1, `mg_op` = 00, load or store) on a message source takes 10 to 00, takes 11 to 10 with a notify, and leaves 00 and 01 unchanged.
- R7: End-of-interrupt on a level source takes 10 or 11 to 00 without the queued re-notify. The level firing rule then runs again, so a line that is still high gives a fresh notify and state 10.
- R8: With `mg_odd_page` = 1, `mg_op` = 1x overwrites the state with `mg_wdata` on both loads and stores. `mg_op` = 01 changes nothing, and a load with `mg_odd_page` = 0 changes nothing.
- R9: Within one cycle, the management operation on a source is applied first. The line and trigger rules then act on its result.
- R10: A notify appears on `ntf_valid`/`ntf_idx` one cycle after the cycle that caused it, at most one per cycle. When several notifies are due, the lowest source number goes first and the others wait until they are served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Type bit write enable |
| cfg_idx | input | IW | Source number for the type write |
| cfg_level | input | 1 | Type value: 1 level, 0 message |
| src_line | input | NUM_SRC | Per-source input lines |
| mg_valid | input | 1 | Management access strobe |
| mg_store | input | 1 | 1 store, 0 load |
| mg_odd_page | input | 1 | 0 trigger page, 1 management page |
| mg_op | input | 2 | 00 end-of-interrupt, 01 query, 1x overwrite |
| mg_idx | input | IW | Source number of the access |
| mg_wdata | input | 2 | P/Q value for an overwrite |
| mg_rvalid | output | 1 | Load data valid |
| mg_rdata | output | 2 | P/Q value before the load's operation |
| ntf_valid | output | 1 | Notify pulse |
| ntf_idx | output | IW | Source number of the notify |

## Verification
An end-of-interrupt and a line event can hit the same source in the same cycle. The bench provokes this by pairing an end-of-interrupt store on a pending message source with a rising edge on its line, which must produce a notify and leave the source pending. It also pairs an end-of-interrupt on a firing level source with its line falling, which must produce no notify and leave the source idle. The constrained random phase keeps producing such collisions on random sources and ops, and every cycle is compared against a bench model that applies the management operation before the line rule.

// File: rtl/pqsrc_pkg.sv
package pqsrc_pkg;

   localparam logic [1:0] PQ_IDLE   = 2'b00;
   localparam logic [1:0] PQ_OFF    = 2'b01;
   localparam logic [1:0] PQ_PEND   = 2'b10;
   localparam logic [1:0] PQ_QUEUED = 2'b11;

   localparam logic [1:0] OP_EOI    = 2'b00;
   localparam logic [1:0] OP_QUERY  = 2'b01;

   typedef struct packed {
      logic [1:0] pq;
      logic       ntf;
   } pq_res_t;

   // event arrival on the full P/Q scheme
   function automatic pq_res_t pq_trigger(input logic [1:0] s);
      pq_res_t r;
      r.pq  = s;
      r.ntf = 1'b0;
      case (s)
         PQ_IDLE:   begin r.pq = PQ_PEND; r.ntf = 1'b1; end
         PQ_PEND,
         PQ_QUEUED: r.pq = PQ_QUEUED;
         default:   r.pq = s;
      endcase
      return r;
   endfunction

   // end of service on the full P/Q scheme
   function automatic pq_res_t pq_eoi(input logic [1:0] s);
      pq_res_t r;
      r.pq  = s;
      r.ntf = 1'b0;
      case (s)
         PQ_PEND:   r.pq = PQ_IDLE;
         PQ_QUEUED: begin r.pq = PQ_PEND; r.ntf = 1'b1; end
         default:   r.pq = s;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pqsrc_cell.sv
module pqsrc_cell
   import pqsrc_pkg::*;
(
   input  logic [1:0] cur_pq,
   input  logic       is_level,
   input  logic       line_now,
   input  logic       line_prev,
   input  logic       mg_hit,
   input  logic       mg_store,
   input  logic       mg_odd_page,
   input  logic [1:0] mg_op,
   input  logic [1:0] mg_wdata,
   output logic [1:0] nxt_pq,
   output logic       notify_req
);

   logic [1:0] st_mg;
   logic       req_eoi;
   logic       trig;
   pq_res_t    eoi_res;
   pq_res_t    trg_res;

   // stage 1: management operation
   always_comb begin
      st_mg   = cur_pq;
      req_eoi = 1'b0;
      eoi_res = pq_eoi(cur_pq);
      if (mg_hit && mg_odd_page) begin
         if (mg_op[1]) begin
            st_mg = mg_wdata;
         end else if (mg_op == OP_EOI) begin
            if (is_level) begin
               if (cur_pq[1]) st_mg = PQ_IDLE;
            end else begin
               st_mg   = eoi_res.pq;
               req_eoi = eoi_res.ntf;
            end
         end
      end
   end

   assign trig = !is_level &&
                 ((line_now && !line_prev) || (mg_hit && !mg_odd_page && mg_store));

   // stage 2: line rules on the management result
   always_comb begin
      trg_res    = pq_trigger(st_mg);
      nxt_pq     = st_mg;
      notify_req = req_eoi;
      if (trig) begin
         nxt_pq     = trg_res.pq;
         notify_req = req_eoi | trg_res.ntf;
      end else if (is_level && line_now && st_mg == PQ_IDLE) begin
         nxt_pq     = PQ_PEND;
         notify_req = 1'b1;
      end
   end

endmodule

// File: rtl/pqsrc_notify_arb.sv
module pqsrc_notify_arb #(
   parameter int NUM_SRC = 8,
   localparam int IW = $clog2(NUM_SRC)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req,
   output logic               ntf_valid,
   output logic [IW-1:0]      ntf_idx
);

   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] all_req;
   logic [NUM_SRC-1:0] grant;
   logic [IW-1:0]      win;
   logic               any;

   assign all_req = pend_q | req;

   always_comb begin
      win   = '0;
      any   = 1'b0;
      grant = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (all_req[i] && !any) begin
            win      = IW'(i);
            any      = 1'b1;
            grant[i] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= '0;
         ntf_valid <= 1'b0;
         ntf_idx   <= '0;
      end else begin
         pend_q    <= all_req & ~grant;
         ntf_valid <= any;
         ntf_idx   <= win;
      end
   end

   // R10
   wait_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q != '0) |=> ntf_valid);

   // R10
   served_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ntf_valid |-> !pend_q[ntf_idx]);

endmodule

// File: rtl/pqsrc_ctrl.sv
module pqsrc_ctrl
   import pqsrc_pkg::*;
#(
   parameter int NUM_SRC = 8,
   localparam int IW     = $clog2(NUM_SRC),
   localparam int NBYTES = NUM_SRC / 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [IW-1:0]      cfg_idx,
   input  logic               cfg_level,
   input  logic [NUM_SRC-1:0] src_line,
   input  logic               mg_valid,
   input  logic               mg_store,
   input  logic               mg_odd_page,
   input  logic [1:0]         mg_op,
   input  logic [IW-1:0]      mg_idx,
   input  logic [1:0]         mg_wdata,
   output logic               mg_rvalid,
   output logic [1:0]         mg_rdata,
   output logic               ntf_valid,
   output logic [IW-1:0]      ntf_idx
);

   initial begin
      if (NUM_SRC < 4 || NUM_SRC % 4 != 0)
         $fatal(1, "NUM_SRC must be a non-zero multiple of 4");
   end

   // state storage: four 2-bit P/Q fields per byte, source i at bits 2i+1:2i
   logic [NBYTES*8-1:0] pq_q;
   logic [NBYTES*8-1:0] pq_d;
   logic [NUM_SRC-1:0]  lvl_type_q;
   logic [NUM_SRC-1:0]  line_q;      // also the asserted flag of level sources
   logic [NUM_SRC-1:0]  req;
   logic [1:0]          rd_sel;

   // type bits: configuration, untouched by reset
   always_ff @(posedge clk) begin
      for (int i = 0; i < NUM_SRC; i++) begin
         if (cfg_we && cfg_idx == IW'(i)) lvl_type_q[i] <= cfg_level;
      end
   end

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      pqsrc_cell u_cell (
         .cur_pq      (pq_q[2*g +: 2]),
         .is_level    (lvl_type_q[g]),
         .line_now    (src_line[g]),
         .line_prev   (line_q[g]),
         .mg_hit      (mg_valid && mg_idx == IW'(g)),
         .mg_store    (mg_store),
         .mg_odd_page (mg_odd_page),
         .mg_op       (mg_op),
         .mg_wdata    (mg_wdata),
         .nxt_pq      (pq_d[2*g +: 2]),
         .notify_req  (req[g])
      );

      // R4
      off_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pq_q[2*g +: 2] == PQ_OFF && !(mg_valid && mg_idx == IW'(g)))
         |=> pq_q[2*g +: 2] == PQ_OFF);
   end

   always_comb begin
      rd_sel = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (mg_idx == IW'(i)) rd_sel = pq_q[2*i +: 2];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pq_q      <= {NBYTES{8'h55}};
         line_q    <= '0;
         mg_rvalid <= 1'b0;
         mg_rdata  <= '0;
      end else begin
         pq_q      <= pq_d;
         line_q    <= src_line;
         mg_rvalid <= mg_valid && !mg_store;
         if (mg_valid && !mg_store) mg_rdata <= rd_sel;
      end
   end

   pqsrc_notify_arb #(.NUM_SRC(NUM_SRC)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .ntf_valid (ntf_valid),
      .ntf_idx   (ntf_idx)
   );

   // R2
   reset_off_chk: assert property (@(posedge clk)
      !rst_n |=> (pq_q == {NBYTES{8'h55}} && !ntf_valid && !mg_rvalid));

   // R1
   load_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mg_valid && !mg_store) |=> mg_rvalid);

   // R1
   store_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mg_valid && !mg_store) |=> !mg_rvalid);

endmodule

// File: tb/pqsrc_ctrl_tb.sv
module pqsrc_ctrl_tb;

   localparam int N  = 8;
   localparam int IW = 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n, cfg_we, cfg_level;
   logic [IW-1:0] cfg_idx, mg_idx, ntf_idx;
   logic [N-1:0]  src_line;
   logic          mg_valid, mg_store, mg_odd_page, mg_rvalid, ntf_valid;
   logic [1:0]    mg_op, mg_wdata, mg_rdata;

   pqsrc_ctrl #(.NUM_SRC(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_level(cfg_level), .src_line(src_line), .mg_valid(mg_valid),
      .mg_store(mg_store), .mg_odd_page(mg_odd_page), .mg_op(mg_op),
      .mg_idx(mg_idx), .mg_wdata(mg_wdata), .mg_rvalid(mg_rvalid),
      .mg_rdata(mg_rdata), .ntf_valid(ntf_valid), .ntf_idx(ntf_idx)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic [1:0] m_pq [N];
   bit         m_typ [N];
   bit         m_line [N];
   bit         m_pend [N];
   bit         exp_nv, exp_rv;
   int         exp_ni;
   logic [1:0] exp_rd;

   function automatic logic [2:0] f_trig(input logic [1:0] s);
      case (s)
         2'b00:        return {2'b10, 1'b1};
         2'b10, 2'b11: return {2'b11, 1'b0};
         default:      return {s, 1'b0};
      endcase
   endfunction

   function automatic logic [2:0] f_eoi(input logic [1:0] s);
      case (s)
         2'b10:   return {2'b00, 1'b0};
         2'b11:   return {2'b10, 1'b1};
         default: return {s, 1'b0};
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // one clock: update the model from the driven inputs, then compare after the edge
   task automatic tick();
      logic [2:0] r;
      logic [1:0] s;
      bit         rq;
      bit         hit;
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_pq[i] = 2'b01; m_line[i] = 0; m_pend[i] = 0;
         end
         exp_nv = 0; exp_rv = 0;
      end else begin
         exp_rv = mg_valid && !mg_store;
         if (exp_rv) exp_rd = m_pq[mg_idx];
         for (int i = 0; i < N; i++) begin
            rq  = 0;
            s   = m_pq[i];
            hit = mg_valid && (int'(mg_idx) == i);
            if (hit && mg_odd_page) begin
               if (mg_op[1]) s = mg_wdata;
               else if (mg_op == 2'b00) begin
                  if (m_typ[i]) begin
                     if (s[1]) s = 2'b00;
                  end else begin
                     r = f_eoi(s); s = r[2:1]; rq = r[0];
                  end
               end
            end
            if (!m_typ[i] && ((src_line[i] && !m_line[i]) || (hit && !mg_odd_page && mg_store))) begin
               r = f_trig(s); s = r[2:1]; if (r[0]) rq = 1;
            end
            if (m_typ[i] && src_line[i] && s == 2'b00) begin
               s = 2'b10; rq = 1;
            end
            m_pq[i]   = s;
            m_line[i] = src_line[i];
            m_pend[i] = m_pend[i] | rq;
         end
         exp_nv = 0;
         for (int i = 0; i < N; i++) begin
            if (m_pend[i] && !exp_nv) begin
               exp_nv = 1; exp_ni = i; m_pend[i] = 0;
            end
         end
      end
      if (cfg_we) m_typ[cfg_idx] = cfg_level;
      @(negedge clk);
      chk(ntf_valid == exp_nv && (!exp_nv || int'(ntf_idx) == exp_ni), "R10 notify",
          {ntf_valid, ntf_idx}, {exp_nv, exp_ni[IW-1:0]});
      chk(mg_rvalid == exp_rv && (!exp_rv || mg_rdata == exp_rd), "R1 load data",
          {mg_rvalid, mg_rdata}, {exp_rv, exp_rd});
   endtask

   task automatic mg_do(input bit st, input bit odd, input logic [1:0] op,
                        input int idx, input logic [1:0] wd);
      mg_valid = 1; mg_store = st; mg_odd_page = odd; mg_op = op;
      mg_idx = IW'(idx); mg_wdata = wd;
      tick();
      mg_valid = 0;
   endtask

   task automatic get(input int idx, output logic [1:0] v);
      mg_do(0, 1, 2'b01, idx, 2'b00);
      v = mg_rdata;
   endtask

   task automatic chk_ntf(input bit v, input int idx, input string tag);
      chk(ntf_valid == v && (!v || int'(ntf_idx) == idx), tag, {ntf_valid, ntf_idx}, {v, IW'(idx)});
   endtask

   task automatic chk_pq(input int idx, input logic [1:0] e, input string tag);
      logic [1:0] v;
      get(idx, v);
      chk(v == e, tag, v, e);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      void'($urandom(32'd2718));
      rst_n = 0; cfg_we = 0; cfg_idx = '0; cfg_level = 0; src_line = '0;
      mg_valid = 0; mg_store = 0; mg_odd_page = 0; mg_op = '0; mg_idx = '0; mg_wdata = '0;
      for (int i = 0; i < N; i++) begin m_typ[i] = 0; m_pq[i] = 2'b01; m_pend[i] = 0; m_line[i] = 0; end
      @(negedge clk);
      // sources 4..7 are level, 0..3 message (R3)
      for (int i = 0; i < N; i++) begin
         cfg_we = 1; cfg_idx = IW'(i); cfg_level = (i >= 4);
         tick();
      end
      cfg_we = 0;
      tick();
      rst_n = 1;
      tick();
      chk_ntf(0, 0, "R2 no notify after reset");
      chk_pq(0, 2'b01, "R2 message source off");
      chk_pq(6, 2'b01, "R2 level source off");

      for (int i = 0; i < N; i++) mg_do(1, 1, 2'b10, i, 2'b00);

      // R4 message trigger
      src_line[0] = 1; tick();
      chk_ntf(1, 0, "R4 rising line notifies");
      tick();
      chk_ntf(0, 0, "R4 held line silent");
      chk_pq(0, 2'b10, "R4 pending");
      src_line[0] = 0; tick();
      src_line[0] = 1; tick();
      chk_ntf(0, 0, "R4 second trigger silent");
      chk_pq(0, 2'b11, "R4 queued");

      // R6 message EOI
      mg_do(1, 1, 2'b00, 0, 2'b00);
      chk_ntf(1, 0, "R6 queued EOI renotifies");
      chk_pq(0, 2'b10, "R6 queued to pending");
      mg_do(0, 1, 2'b00, 0, 2'b00);
      chk(mg_rdata == 2'b10, "R1 EOI load returns old state", mg_rdata, 2'b10);
      chk_ntf(0, 0, "R6 pending EOI silent");
      chk_pq(0, 2'b00, "R6 pending to idle");
      mg_do(1, 1, 2'b00, 0, 2'b00);
      chk_pq(0, 2'b00, "R6 idle EOI unchanged");

      // R5 / R7 level source
      src_line[4] = 1; tick();
      chk_ntf(1, 4, "R5 level fires");
      chk_pq(4, 2'b10, "R5 level pending");
      mg_do(1, 1, 2'b00, 4, 2'b00);
      chk_ntf(1, 4, "R7 still-high line refires");
      chk_pq(4, 2'b10, "R7 refire pending");
      src_line[4] = 0; tick();
      chk_ntf(0, 0, "R5 deassert silent");
      mg_do(0, 1, 2'b00, 4, 2'b00);
      chk_ntf(0, 0, "R7 low line no refire");
      chk_pq(4, 2'b00, "R7 back to idle");
      mg_do(1, 0, 2'b00, 4, 2'b00);
      chk_ntf(0, 0, "R5 trigger page ignored notify");
      chk_pq(4, 2'b00, "R5 trigger page ignored state");
      mg_do(1, 1, 2'b10, 4, 2'b11);
      mg_do(1, 1, 2'b00, 4, 2'b00);
      chk_ntf(0, 0, "R7 level queued EOI no renotify");
      chk_pq(4, 2'b00, "R7 level queued to idle");

      // R10 priority
      src_line[1] = 1; src_line[2] = 1; src_line[5] = 1; tick();
      chk_ntf(1, 1, "R10 lowest first");
      tick(); chk_ntf(1, 2, "R10 second");
      tick(); chk_ntf(1, 5, "R10 third");
      tick(); chk_ntf(0, 0, "R10 drained");

      // R9 same-cycle EOI and line event
      src_line[1] = 0; tick();
      src_line[1] = 1; mg_do(1, 1, 2'b00, 1, 2'b00);
      chk_ntf(1, 1, "R9 EOI then rising line");
      chk_pq(1, 2'b10, "R9 message stays pending");
      src_line[5] = 0; mg_do(1, 1, 2'b00, 5, 2'b00);
      chk_ntf(0, 0, "R9 EOI with falling level line");
      chk_pq(5, 2'b00, "R9 level idle");

      // R8 overwrite / query / trigger-page load
      mg_do(0, 1, 2'b10, 3, 2'b01);
      chk(mg_rdata == 2'b00, "R8 overwrite load returns old", mg_rdata, 2'b00);
      src_line[3] = 1; tick();
      chk_ntf(0, 0, "R4 off source silent");
      mg_do(1, 0, 2'b00, 3, 2'b00);
      chk_pq(3, 2'b01, "R4 off stays off");
      mg_do(1, 1, 2'b01, 3, 2'b00);
      chk_pq(3, 2'b01, "R8 query store no effect");
      mg_do(0, 0, 2'b00, 2, 2'b00);
      chk_pq(2, 2'b10, "R8 trigger page load no effect");
      mg_do(1, 0, 2'b00, 2, 2'b00);
      chk_ntf(0, 0, "R4 software trigger on pending silent");
      chk_pq(2, 2'b11, "R4 software trigger queues");

      // R3 type survives reset
      src_line[4] = 1; src_line[0] = 1;
      rst_n = 0; tick(); tick();
      rst_n = 1; tick(); tick();
      chk_pq(6, 2'b01, "R2 off after second reset");
      mg_do(1, 1, 2'b10, 4, 2'b00);
      chk_ntf(1, 4, "R3 level type kept");
      mg_do(1, 1, 2'b10, 0, 2'b00);
      chk_ntf(0, 0, "R3 message type kept");

      // constrained random with collisions
      for (int c = 0; c < 4000; c++) begin
         for (int i = 0; i < N; i++)
            if ($urandom % 8 == 0) src_line[i] = ~src_line[i];
         mg_valid    = ($urandom % 3 == 0);
         mg_store    = $urandom % 2;
         mg_odd_page = ($urandom % 5 != 0);
         mg_op       = 2'($urandom);
         mg_idx      = IW'($urandom);
         mg_wdata    = 2'($urandom);
         tick();
      end
      mg_valid = 0;
      repeat (12) tick();
      finish_run();
   end

endmodule